// File: doc/BRIEF.md
# Multi-Port RAM with Per-Port Read Configuration

This block is a parameterised random-access memory with several write ports and several read ports. All write ports share one write clock, whose active edge is selected by a parameter. Each write port has an enable, an address and a data word. When two write ports target the same word on the same edge, the port with the larger index wins.

Each read port is configured on its own through parameter vectors that hold one bit per read port. A port is either clocked, so that it captures the word into a register on its clock edge under a clock enable, or unclocked, so that it follows the memory contents combinationally. A clocked port picks its active edge. It also picks what a read returns when a write hits the same word in the same cycle: the newly written word or the word held before the write. Returning the new word needs the read port to share the write clock and edge, and the block only builds the address-compare bypass when the edges match.

The memory holds 2^ADDR_W words and has no reset. A synchronous active-high reset clears only the registered read outputs.

Top module: `mp_ram`

## Requirements
- R1: On the active write-clock edge, each write port whose enable is 1 stores its data at its address. A port whose enable is 0 leaves the memory unchanged.
- R2: When several enabled write ports use the same address on one edge, the word stored is the data of the highest-indexed of those ports.
- R3: A clocked read port with its enable at 1 loads the addressed word on its active edge. With its enable at 0 it holds its output unchanged.
- R4: Bit i of RD_RISE set to 1 makes clocked read port i act on the rising edge of its clock. Set to 0, the port acts on the falling edge. With default parameters, port 2 acts on the falling edge and returns the memory contents as they stand after the preceding rising-edge write.
- R5: A clocked port with bit i of RD_NEW set to 1 and the same edge as the write clock returns the write data on a same-edge, same-address write. If several write ports hit that address, it returns the data of the highest-indexed one. With default parameters this is port 0.
- R6: A clocked port with bit i of RD_NEW set to 0 returns the word held before a same-cycle write to its address. With default parameters this is port 1.
- R7: A read port with bit i of RD_SYNC set to 0 ignores its clock and enable and shows the addressed word combinationally. After a write edge it shows the updated word. With default parameters this is port 3.
- R8: While rst is 1 on a clocked read port's active edge, that port's output becomes 0. The memory contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset of the registered read outputs |
| wclk | input | 1 | Write clock shared by all write ports |
| w_en | input | N_WR | Write enable, one bit per write port |
| w_addr | input | N_WR*ADDR_W | Write addresses, port j in bits [j*ADDR_W +: ADDR_W] |
| w_data | input | N_WR*DATA_W | Write data, port j in bits [j*DATA_W +: DATA_W] |
| r_clk | input | N_RD | Read clock, one bit per read port |
| r_ce | input | N_RD | Read clock enable, one bit per read port |
| r_addr | input | N_RD*ADDR_W | Read addresses, port i in bits [i*ADDR_W +: ADDR_W] |
| r_data | output | N_RD*DATA_W | Read data, port i in bits [i*DATA_W +: DATA_W] |

## Verification
On every cycle the assertions check four behaviours. A disabled clocked port holds its output. A reset clears its output. A new-data port returns the highest write port's data when that port hits its address. An unclocked port shows the highest write port's data after the edge that wrote it. Old-data returns, falling-edge capture, the result of colliding writes, and the memory surviving a reset can only be shown by the bench scenarios, which compare every port against a shadow array.

// File: rtl/mp_ram_pkg.sv
package mp_ram_pkg;
  // A clocked port may take the bypass only when it captures on the write edge.
  function automatic bit bypass_ok(input bit sync, input bit want_new,
                                   input bit rd_rise, input bit wr_rise);
    return sync && want_new && (rd_rise == wr_rise);
  endfunction
endpackage

// File: rtl/mp_ram_store.sv
module mp_ram_store #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int N_WR    = 2,
  parameter int N_RD    = 4,
  parameter bit WR_RISE = 1'b1
) (
  input  logic                     wclk,
  input  logic [N_WR-1:0]          w_en,
  input  logic [N_WR*ADDR_W-1:0]   w_addr,
  input  logic [N_WR*DATA_W-1:0]   w_data,
  input  logic [N_RD*ADDR_W-1:0]   r_addr,
  output logic [N_RD*DATA_W-1:0]   r_raw
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wck;

  assign wck = WR_RISE ? wclk : ~wclk;

  // Later iterations override earlier ones: the highest-indexed port wins.
  always_ff @(posedge wck) begin
    for (int j = 0; j < N_WR; j++) begin
      if (w_en[j]) mem[w_addr[j*ADDR_W +: ADDR_W]] <= w_data[j*DATA_W +: DATA_W];
    end
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_tap
    assign r_raw[i*DATA_W +: DATA_W] = mem[r_addr[i*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/mp_ram_bypass.sv
module mp_ram_bypass #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int N_WR   = 2
) (
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [N_WR-1:0]          w_en,
  input  logic [N_WR*ADDR_W-1:0]   w_addr,
  input  logic [N_WR*DATA_W-1:0]   w_data,
  output logic                     hit,
  output logic [DATA_W-1:0]        hit_data
);
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int j = 0; j < N_WR; j++) begin
      if (w_en[j] && (w_addr[j*ADDR_W +: ADDR_W] == rd_addr)) begin
        hit      = 1'b1;
        hit_data = w_data[j*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/mp_ram_rd_port.sv
module mp_ram_rd_port #(
  parameter int DATA_W = 8,
  parameter bit SYNC   = 1'b1,
  parameter bit RISE   = 1'b1,
  parameter bit BYPASS = 1'b0
) (
  input  logic              rst,
  input  logic              clk,
  input  logic              ce,
  input  logic [DATA_W-1:0] raw,
  input  logic              byp_hit,
  input  logic [DATA_W-1:0] byp_data,
  output logic [DATA_W-1:0] q
);
  if (SYNC) begin : g_sync
    logic              ck;
    logic [DATA_W-1:0] q_r;
    assign ck = RISE ? clk : ~clk;
    always_ff @(posedge ck) begin
      if (rst)     q_r <= '0;
      else if (ce) q_r <= (BYPASS && byp_hit) ? byp_data : raw;
    end
    assign q = q_r;
  end else begin : g_async
    logic unused_in;
    assign unused_in = ^{rst, clk, ce, byp_hit, byp_data};
    assign q = raw;
  end
endmodule

// File: rtl/mp_ram.sv
module mp_ram
  import mp_ram_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 4,
  parameter int          N_WR    = 2,
  parameter int          N_RD    = 4,
  parameter bit          WR_RISE = 1'b1,
  parameter bit [N_RD-1:0] RD_SYNC = 4'b0111,
  parameter bit [N_RD-1:0] RD_RISE = 4'b0011,
  parameter bit [N_RD-1:0] RD_NEW  = 4'b0101
) (
  input  logic                     rst,
  input  logic                     wclk,
  input  logic [N_WR-1:0]          w_en,
  input  logic [N_WR*ADDR_W-1:0]   w_addr,
  input  logic [N_WR*DATA_W-1:0]   w_data,
  input  logic [N_RD-1:0]          r_clk,
  input  logic [N_RD-1:0]          r_ce,
  input  logic [N_RD*ADDR_W-1:0]   r_addr,
  output logic [N_RD*DATA_W-1:0]   r_data
);
  logic [N_RD*DATA_W-1:0] raw;

  mp_ram_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WR(N_WR), .N_RD(N_RD), .WR_RISE(WR_RISE)
  ) u_store (
    .wclk(wclk), .w_en(w_en), .w_addr(w_addr), .w_data(w_data),
    .r_addr(r_addr), .r_raw(raw)
  );

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    localparam bit BYP = bypass_ok(RD_SYNC[i], RD_NEW[i], RD_RISE[i], WR_RISE);
    logic              hit;
    logic [DATA_W-1:0] hit_data;

    mp_ram_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WR(N_WR)) u_byp (
      .rd_addr(r_addr[i*ADDR_W +: ADDR_W]), .w_en(w_en), .w_addr(w_addr),
      .w_data(w_data), .hit(hit), .hit_data(hit_data)
    );

    mp_ram_rd_port #(
      .DATA_W(DATA_W), .SYNC(RD_SYNC[i]), .RISE(RD_RISE[i]), .BYPASS(BYP)
    ) u_port (
      .rst(rst), .clk(r_clk[i]), .ce(r_ce[i]), .raw(raw[i*DATA_W +: DATA_W]),
      .byp_hit(hit), .byp_data(hit_data), .q(r_data[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/mp_ram_chk.sv
module mp_ram_chk #(
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 4,
  parameter int          N_WR    = 2,
  parameter int          N_RD    = 4,
  parameter bit          WR_RISE = 1'b1,
  parameter bit [N_RD-1:0] RD_SYNC = 4'b0111,
  parameter bit [N_RD-1:0] RD_RISE = 4'b0011,
  parameter bit [N_RD-1:0] RD_NEW  = 4'b0101
) (
  input logic                     rst,
  input logic                     wclk,
  input logic [N_WR-1:0]          w_en,
  input logic [N_WR*ADDR_W-1:0]   w_addr,
  input logic [N_WR*DATA_W-1:0]   w_data,
  input logic [N_RD-1:0]          r_clk,
  input logic [N_RD-1:0]          r_ce,
  input logic [N_RD*ADDR_W-1:0]   r_addr,
  input logic [N_RD*DATA_W-1:0]   r_data
);
  localparam int TOPW = N_WR - 1;
  logic wck;
  assign wck = WR_RISE ? wclk : ~wclk;

  for (genvar i = 0; i < N_RD; i++) begin : g_p
    if (RD_SYNC[i]) begin : g_s
      logic ck;
      assign ck = RD_RISE[i] ? r_clk[i] : ~r_clk[i];

      a_r3_hold_when_idle: assert property (@(posedge ck) disable iff (rst)
        !r_ce[i] |=> $stable(r_data[i*DATA_W +: DATA_W]));

      a_r8_reset_clears: assert property (@(posedge ck) disable iff (rst)
        $past(rst) |-> (r_data[i*DATA_W +: DATA_W] == '0));

      if (RD_NEW[i] && (RD_RISE[i] == WR_RISE)) begin : g_n
        a_r5_new_data: assert property (@(posedge ck) disable iff (rst)
          (r_ce[i] && w_en[TOPW] &&
           w_addr[TOPW*ADDR_W +: ADDR_W] == r_addr[i*ADDR_W +: ADDR_W])
          |=> (r_data[i*DATA_W +: DATA_W] == $past(w_data[TOPW*DATA_W +: DATA_W])));
      end
    end else begin : g_a
      a_r7_async_updates: assert property (@(posedge wck) disable iff (rst)
        (w_en[TOPW] && w_addr[TOPW*ADDR_W +: ADDR_W] == r_addr[i*ADDR_W +: ADDR_W])
        |=> ($stable(r_addr[i*ADDR_W +: ADDR_W]) ->
             r_data[i*DATA_W +: DATA_W] == $past(w_data[TOPW*DATA_W +: DATA_W])));
    end
  end
endmodule

bind mp_ram mp_ram_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WR(N_WR), .N_RD(N_RD), .WR_RISE(WR_RISE),
  .RD_SYNC(RD_SYNC), .RD_RISE(RD_RISE), .RD_NEW(RD_NEW)
) u_chk (
  .rst(rst), .wclk(wclk), .w_en(w_en), .w_addr(w_addr), .w_data(w_data),
  .r_clk(r_clk), .r_ce(r_ce), .r_addr(r_addr), .r_data(r_data)
);

// File: tb/mp_ram_tb.sv
module mp_ram_tb;
  localparam int PERIOD = 10;
  localparam int DW = 8, AW = 4, NW = 2, NR = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] wd [NW];
  logic [AW-1:0] wa [NW];
  logic          we [NW];
  logic [AW-1:0] ra [NR];
  logic          ce [NR];

  logic [NW-1:0]    w_en;
  logic [NW*AW-1:0] w_addr;
  logic [NW*DW-1:0] w_data;
  logic [NR-1:0]    r_ce;
  logic [NR*AW-1:0] r_addr;
  logic [NR*DW-1:0] r_data;
  logic [NR-1:0]    r_clk;

  for (genvar j = 0; j < NW; j++) begin : g_w
    assign w_en[j] = we[j];
    assign w_addr[j*AW +: AW] = wa[j];
    assign w_data[j*DW +: DW] = wd[j];
  end
  for (genvar i = 0; i < NR; i++) begin : g_r
    assign r_ce[i] = ce[i];
    assign r_addr[i*AW +: AW] = ra[i];
    assign r_clk[i] = clk;
  end

  mp_ram u_dut (
    .rst(rst), .wclk(clk), .w_en(w_en), .w_addr(w_addr), .w_data(w_data),
    .r_clk(r_clk), .r_ce(r_ce), .r_addr(r_addr), .r_data(r_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] sh [DEPTH];
  logic [DW-1:0] prev [3];
  bit chk_sync = 0, chk_async = 0;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rd(input int p);
    return r_data[p*DW +: DW];
  endfunction

  // Called at posedge+2 with inputs set; returns at next posedge+2.
  task automatic step();
    logic [DW-1:0] e [3];
    logic [DW-1:0] e3;
    for (int p = 0; p < 3; p++) begin
      if (rst) e[p] = '0;
      else if (!ce[p]) e[p] = prev[p];
      else begin
        e[p] = sh[ra[p]];
        if (p == 0) for (int j = 0; j < NW; j++) if (we[j] && wa[j] == ra[0]) e[p] = wd[j];
      end
    end
    e3 = sh[ra[3]];
    #6;
    if (chk_async) chk("R7 async port3", rd(3), e3);
    @(posedge clk);
    for (int j = 0; j < NW; j++) if (we[j]) sh[wa[j]] = wd[j];
    #1;
    if (chk_sync) begin
      chk(ce[0] || rst ? "R5 port0" : "R3 hold port0", rd(0), e[0]);
      chk(ce[1] || rst ? "R6 port1" : "R3 hold port1", rd(1), e[1]);
      chk(ce[2] || rst ? "R4 port2" : "R3 hold port2", rd(2), e[2]);
    end
    for (int p = 0; p < 3; p++) prev[p] = e[p];
    #1;
  endtask

  task automatic idle();
    for (int j = 0; j < NW; j++) begin we[j] = 0; wa[j] = '0; wd[j] = '0; end
    for (int i = 0; i < NR; i++) begin ra[i] = '0; ce[i] = 1; end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    repeat (3) @(posedge clk);
    #2;
    chk_sync = 1;
    step(); step();              // R8 reset state of clocked ports
    rst = 0;
    // fill memory through port 0
    for (int a = 0; a < DEPTH; a++) begin
      idle(); we[0] = 1; wa[0] = AW'(a); wd[0] = DW'(a * 7 + 3);
      step();
    end
    chk_async = 1;
    // R1: disabled write has no effect
    idle(); wa[1] = 4'd6; wd[1] = 8'hEE;
    for (int i = 0; i < NR; i++) ra[i] = 4'd6;
    step(); step();
    chk("R1 disabled write", rd(1), DW'(6 * 7 + 3));
    // R2: collision on address 5, all ports reading it
    idle();
    we[0] = 1; wa[0] = 4'd5; wd[0] = 8'hAA;
    we[1] = 1; wa[1] = 4'd5; wd[1] = 8'h55;
    for (int i = 0; i < NR; i++) ra[i] = 4'd5;
    step();
    idle(); for (int i = 0; i < NR; i++) ra[i] = 4'd5;
    step();
    chk("R2 higher port wins", rd(1), 8'h55);
    // R7: async port ignores ce
    idle(); for (int i = 0; i < NR; i++) ce[i] = 0;
    ra[3] = 4'd5; we[0] = 1; wa[0] = 4'd5; wd[0] = 8'h3C;
    step(); #4;
    chk("R7 ce ignored", rd(3), 8'h3C);
    #(PERIOD - 4);
    // random phase
    for (int n = 0; n < 400; n++) begin
      bit narrow;
      narrow = ($urandom % 2) == 0;
      for (int j = 0; j < NW; j++) begin
        we[j] = ($urandom % 3) != 0;
        wa[j] = narrow ? AW'($urandom % 3) : AW'($urandom);
        wd[j] = DW'($urandom);
      end
      for (int i = 0; i < NR; i++) begin
        ra[i] = narrow ? AW'($urandom % 3) : AW'($urandom);
        ce[i] = ($urandom % 5) != 0;
      end
      step();
    end
    // R8: reset leaves memory intact
    idle(); rst = 1;
    for (int i = 0; i < NR; i++) ra[i] = 4'd9;
    step(); step();
    rst = 0;
    chk("R8 memory kept", rd(3), sh[9]);
    step();
    chk("R8 read after reset", rd(1), sh[9]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule